// File: doc/BRIEF.md
# Grouped Interrupt Aggregation Controller

This controller gathers sixteen external request lines and presents them to a processor as four grouped interrupt outputs and one non-maskable output. Every line passes through a two-stage synchronizer. Lines 0 to 14 are active-low and level-sensitive. Line 15 is a push-button input that raises its request only on a falling edge. Each request is held in a flag register. Software can read the flags and clear them, and a mask register decides which flags may reach the group outputs.

Each group output is a registered OR over the pending, unmasked flags that belong to its fixed group. An interrupt handler reads the flag register to find out which line fired. It then writes the inverse of the bits it has serviced to clear those bits. A typical start-up sequence masks lines 1 to 14 and then writes zero to the flag register to clear every stale request.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFFFF, the flag register reads 0x0000, and all outputs are low.
- R2: A write at byte offset 0x4 loads the mask register, and a read at 0x4 returns its value. In the mask register a 1 blocks a line and a 0 lets it through.
- R3: A write at byte offset 0xC clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R4: Lines 0 to 14 request while low. The flag is set at the third rising clock edge after the line falls. A read at 0xC returns the raw flags, whatever the mask holds.
- R5: Group output g is high when flags AND NOT mask AND G[g] is non-zero, where G[0]=0x0028, G[1]=0x0050, G[2]=0x1C00 and G[3]=0x6386.
- R6: If a level line is still low when its flag is cleared, the flag reads 0 just after the clearing edge and is set again at the next edge.
- R7: Line 0 is latched and readable but drives no group output.
- R8: Line 15 sets its flag only on a high-to-low transition, so holding the line low does not set the flag again after a clear. The non-maskable output follows flag 15 whatever mask bit 15 holds.
- R9: Writes to offsets other than 0x4 and 0xC change neither register, and reads of other offsets return 0.
- R10: Every output is registered. It changes at the clock edge after the flag or mask change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n_i | input | 16 | Request lines. Lines 0 to 14 are active-low levels; line 15 is falling-edge |
| addr_i | input | 4 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| cpu_irq_o | output | 4 | Grouped interrupt outputs, active high |
| nmi_o | output | 1 | Non-maskable interrupt output |

## Verification
The mask and flag registers can both be read on the bus. A bit that is set or cleared wrongly therefore shows up in the same cycle as a wrong read value, and one edge later as a wrong group output. An error in the edge detector on line 15 shows up as a flag that sets again while the line is held low, or as a flag that never sets. A group mapping error sends a single line to the wrong output bit, one cycle after that line's flag rises.

// File: rtl/irq_group_pkg.sv
package irq_group_pkg;
  localparam int LINES  = 16;
  localparam int GROUPS = 4;
  localparam int ADDR_W = 4;
  localparam int NMI_LINE = 15;

  typedef logic [LINES-1:0]  line_vec_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t     MASK_ADDR  = 4'h4;
  localparam addr_t     FLAG_ADDR  = 4'hC;
  localparam line_vec_t EDGE_LINES = 16'h8000;
  localparam line_vec_t MASK_RESET = 16'hFFFF;

  // fixed membership of each line in each output group
  function automatic line_vec_t group_mask(input int g);
    case (g)
      0:       return 16'h0028;
      1:       return 16'h0050;
      2:       return 16'h1C00;
      3:       return 16'h6386;
      default: return '0;
    endcase
  endfunction

  function automatic line_vec_t live_pending(input line_vec_t flags,
                                             input line_vec_t mask);
    return flags & ~mask;
  endfunction

  // level sets are suppressed in a clearing cycle, edge sets are never lost
  function automatic line_vec_t next_flags(input line_vec_t flags,
                                           input line_vec_t keep,
                                           input line_vec_t lvl,
                                           input line_vec_t edg);
    return (flags & keep) | (lvl & keep) | edg;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else if (s == 0) stage_q[s] <= async_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect
  import irq_group_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t line_n_i,
  output line_vec_t level_set_o,
  output line_vec_t edge_set_o
);
  line_vec_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= line_n_i;
  end

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      if (EDGE_LINES[i]) begin : g_edge
        assign edge_set_o[i]  = prev_q[i] & ~line_n_i[i];
        assign level_set_o[i] = 1'b0;
      end else begin : g_level
        assign edge_set_o[i]  = 1'b0;
        assign level_set_o[i] = ~line_n_i[i];
      end
    end
  endgenerate
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_group_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  addr_t     addr_i,
  input  logic      wr_en_i,
  input  line_vec_t wdata_i,
  input  line_vec_t level_set_i,
  input  line_vec_t edge_set_i,
  output line_vec_t mask_o,
  output line_vec_t flag_o,
  output line_vec_t rdata_o
);
  line_vec_t mask_q, flag_q, keep;
  logic      mask_wr, flag_wr;

  assign mask_wr = wr_en_i && (addr_i == MASK_ADDR);
  assign flag_wr = wr_en_i && (addr_i == FLAG_ADDR);
  assign keep    = flag_wr ? wdata_i : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_RESET;
    else if (mask_wr) mask_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= next_flags(flag_q, keep, level_set_i, edge_set_i);
  end

  always_comb begin
    case (addr_i)
      MASK_ADDR: rdata_o = mask_q;
      FLAG_ADDR: rdata_o = flag_q;
      default:   rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import irq_group_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  line_vec_t         flag_i,
  input  line_vec_t         mask_i,
  output logic [GROUPS-1:0] cpu_irq_o,
  output logic              nmi_o
);
  line_vec_t pend;
  assign pend = live_pending(flag_i, mask_i);

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_out
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cpu_irq_o[g] <= 1'b0;
        else        cpu_irq_o[g] <= |(pend & group_mask(g));
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_o <= 1'b0;
    else        nmi_o <= flag_i[NMI_LINE];
  end
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_group_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  req_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [LINES-1:0]  wdata_i,
  output logic [LINES-1:0]  rdata_o,
  output logic [GROUPS-1:0] cpu_irq_o,
  output logic              nmi_o
);
  line_vec_t line_sync, level_set, edge_set, mask_q, flag_q;

  irq_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(req_n_i), .sync_o(line_sync)
  );

  irq_detect u_detect (
    .clk(clk), .rst_n(rst_n), .line_n_i(line_sync),
    .level_set_o(level_set), .edge_set_o(edge_set)
  );

  irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .level_set_i(level_set), .edge_set_i(edge_set),
    .mask_o(mask_q), .flag_o(flag_q), .rdata_o(rdata_o)
  );

  irq_merge u_merge (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_q), .mask_i(mask_q),
    .cpu_irq_o(cpu_irq_o), .nmi_o(nmi_o)
  );
endmodule

// File: rtl/irq_group_ctrl_chk.sv
module irq_group_ctrl_chk
  import irq_group_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [LINES-1:0]  wdata_i,
  input logic [LINES-1:0]  mask_q,
  input logic [LINES-1:0]  flag_q,
  input logic [LINES-1:0]  edge_set,
  input logic [GROUPS-1:0] cpu_irq_o,
  input logic              nmi_o
);
  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == MASK_ADDR) |=> (mask_q == $past(wdata_i)));

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == MASK_ADDR) |=> $stable(mask_q));

  assert_zero_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == FLAG_ADDR) |=>
      ((flag_q & ~$past(wdata_i) & ~$past(edge_set)) == '0));

  assert_nmi_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (nmi_o == $past(flag_q[NMI_LINE])));

  assert_edge_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[NMI_LINE]) |-> $past(edge_set[NMI_LINE]));

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assert_group_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cpu_irq_o[g] == |($past(flag_q & ~mask_q) & group_mask(g))));
    end
  endgenerate
endmodule

bind irq_group_ctrl irq_group_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .mask_q(mask_q), .flag_q(flag_q), .edge_set(edge_set),
  .cpu_irq_o(cpu_irq_o), .nmi_o(nmi_o)
);

// File: tb/irq_group_ctrl_bench.sv
`timescale 1ns/1ps
module irq_group_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_n = 16'hFFFF;
  logic [3:0]  addr = 4'h0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic [3:0]  cpu_irq;
  logic        nmi;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [15:0] GRP [4] = '{16'h0028, 16'h0050, 16'h1C00, 16'h6386};

  always #2.5 clk = ~clk;

  irq_group_ctrl u_irq_group_ctrl (
    .clk(clk), .rst_n(rst_n), .req_n_i(req_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .cpu_irq_o(cpu_irq), .nmi_o(nmi)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  function automatic logic [3:0] exp_out(input logic [15:0] pend);
    logic [3:0] r;
    for (int g = 0; g < 4; g++) r[g] = |(pend & GRP[g]);
    return r;
  endfunction

  task automatic clear_all();
    req_n = 16'hFFFF;
    cyc(3);
    bus_wr(4'hC, 16'h0000);
    cyc(1);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    bus_rd(4'h4, v); chk("R1 mask", v, 16'hFFFF);
    bus_rd(4'hC, v); chk("R1 flags", v, 16'h0000);
    chk("R1 outputs", {11'h0, nmi, cpu_irq}, 16'h0);
  endtask

  task automatic t_mask();
    logic [15:0] v;
    bus_wr(4'h4, 16'h7FFE);
    bus_rd(4'h4, v); chk("R2 mask readback", v, 16'h7FFE);
  endtask

  task automatic t_level_masked();
    logic [15:0] v;
    req_n[3] = 1'b0;
    cyc(2); bus_rd(4'hC, v); chk("R4 flag not yet", v, 16'h0000);
    cyc(1); bus_rd(4'hC, v); chk("R4 raw flag while masked", v, 16'h0008);
    cyc(1); chk("R5 masked no output", {12'h0, cpu_irq}, 16'h0);
    clear_all();
    bus_rd(4'hC, v); chk("R3 clear all", v, 16'h0000);
  endtask

  task automatic t_latency();
    logic [15:0] v;
    req_n[3] = 1'b0;
    cyc(4);
    bus_wr(4'h4, 16'h0000);
    bus_rd(4'h4, v); chk("R2 unmask", v, 16'h0000);
    chk("R10 output not yet", {12'h0, cpu_irq}, 16'h0);
    cyc(1); chk("R10 output one edge later", {12'h0, cpu_irq}, 16'h0001);
    req_n[3] = 1'b1;
    cyc(3);
    bus_wr(4'hC, 16'h0000);
    chk("R10 output held until next edge", {12'h0, cpu_irq}, 16'h0001);
    cyc(1); chk("R10 output drops", {12'h0, cpu_irq}, 16'h0);
  endtask

  task automatic t_groups();
    logic [15:0] v;
    for (int i = 0; i < 15; i++) begin
      req_n[i] = 1'b0;
      cyc(4);
      bus_rd(4'hC, v); chk($sformatf("R4 flag line %0d", i), v, 16'h1 << i);
      chk(i == 0 ? "R7 line 0 no output" : $sformatf("R5 group line %0d", i),
          {12'h0, cpu_irq}, {12'h0, exp_out(16'h1 << i)});
      clear_all();
    end
  endtask

  task automatic t_select_clear();
    logic [15:0] v;
    req_n[2] = 1'b0; req_n[9] = 1'b0;
    cyc(3);
    req_n = 16'hFFFF;
    cyc(3);
    bus_rd(4'hC, v); chk("R3 two flags", v, 16'h0204);
    bus_wr(4'hC, 16'hFFFB);
    bus_rd(4'hC, v); chk("R3 clear one", v, 16'h0200);
    bus_wr(4'hC, 16'hFFFF);
    bus_rd(4'hC, v); chk("R3 ones keep", v, 16'h0200);
    bus_wr(4'hC, 16'h0000);
  endtask

  task automatic t_hold();
    logic [15:0] v;
    req_n[5] = 1'b0;
    cyc(3);
    bus_wr(4'hC, 16'h0000);
    bus_rd(4'hC, v); chk("R6 cleared", v, 16'h0000);
    cyc(1); bus_rd(4'hC, v); chk("R6 re-set", v, 16'h0020);
    clear_all();
  endtask

  task automatic t_edge();
    logic [15:0] v;
    bus_wr(4'h4, 16'hFFFF);
    req_n[15] = 1'b0;
    cyc(3); bus_rd(4'hC, v); chk("R8 edge flag", v, 16'h8000);
    chk("R10 nmi not yet", {15'h0, nmi}, 16'h0);
    cyc(1); chk("R8 nmi despite mask", {15'h0, nmi}, 16'h1);
    chk("R8 no group output", {12'h0, cpu_irq}, 16'h0);
    bus_wr(4'hC, 16'h0000);
    cyc(4);
    bus_rd(4'hC, v); chk("R8 held low no re-set", v, 16'h0000);
    chk("R8 nmi low", {15'h0, nmi}, 16'h0);
    req_n[15] = 1'b1;
    cyc(4); bus_rd(4'hC, v); chk("R8 rising no flag", v, 16'h0000);
    req_n[15] = 1'b0;
    cyc(3); bus_rd(4'hC, v); chk("R8 second edge", v, 16'h8000);
  endtask

  task automatic t_other_addr();
    logic [15:0] v;
    bus_wr(4'h8, 16'h1234);
    bus_wr(4'h0, 16'h0000);
    bus_rd(4'h4, v); chk("R9 mask unchanged", v, 16'hFFFF);
    bus_rd(4'hC, v); chk("R9 flags unchanged", v, 16'h8000);
    bus_rd(4'h8, v); chk("R9 other read zero", v, 16'h0000);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_mask();
    t_level_masked();
    t_latency();
    t_groups();
    t_select_clear();
    t_hold();
    t_edge();
    t_other_addr();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule